// File: doc/BRIEF.md
# Programmable Input Pin Toggle Generator

This block drives square waves onto chosen bits of three byte-wide input port images. It has eighteen independent channels, each tied permanently to one bit of one port. A host arms a channel with a high duration, a low duration (both counted in clock cycles) and a transition repeat count. From then on the channel flips its bit whenever its current interval runs out. After the programmed number of transitions it goes idle by itself.

Each port image is kept in the block and is presented on its own byte output. A one-cycle update strobe accompanies every change. The host can stop any channel at any time, and a global cancel input stops all channels at once. In both cases the port bytes are left as they are. A per-channel busy vector shows which channels still have a transition pending.

Top module: `pin_toggle_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, all three port bytes, all update strobes and the whole busy vector are zero after that edge.
- R2: A transition inverts only the channel's own bit of its port byte. Every other bit of all three ports keeps its value. Port A bits 6..3 and port D bits 7..6 never change.
- R3: An arm command (`cmd_op` = 2'b01) sampled at edge E0 schedules the first transition for edge E0+N. N is the high duration if the channel's bit is 1 at E0 and the low duration if it is 0.
- R4: After each transition the next one follows after the high duration if the bit is now 1, and after the low duration if it is now 0.
- R5: A repeat value R yields exactly R+1 transitions. The busy bit clears at the edge of the last one.
- R6: A repeat value of all ones (32'hFFFF_FFFF) never expires. The channel keeps toggling until it is stopped or cancelled.
- R7: A duration of zero is treated as one cycle.
- R8: A stop command (`cmd_op` = 2'b10) clears the channel's busy bit and cancels its pending transition, even if that transition is due at the same edge. The port bytes are left unchanged.
- R9: `cancel_all` high at an edge clears every busy bit and cancels all pending transitions without touching the port bytes.
- R10: Arming a channel that is already busy discards its old schedule and times the next transition from the new arm edge.
- R11: The channel map is fixed: indices 0..3 drive port A bits 7, 2, 1, 0; indices 4..11 drive port C bits 0..7; indices 12..17 drive port D bits 0..5. A command whose `cmd_chan` is 18 or more has no effect.
- R12: A port's update strobe is high for exactly the cycle after an edge that changed that byte. Channels of one port that fire at the same edge change the byte together under a single strobe.
- R13: A channel's busy bit is 1 from its arm edge for as long as a transition is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cancel_all | input | 1 | Cancel every pending transition |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 2 | 01 arm, 10 stop, others ignored |
| cmd_chan | input | 5 | Target channel index |
| cmd_hi | input | 32 | High duration in cycles (arm) |
| cmd_lo | input | 32 | Low duration in cycles (arm) |
| cmd_rep | input | 32 | Repeat count (arm) |
| port_a_o | output | 8 | Port A image |
| port_a_upd | output | 1 | Port A changed at last edge |
| port_c_o | output | 8 | Port C image |
| port_c_upd | output | 1 | Port C changed at last edge |
| port_d_o | output | 8 | Port D image |
| port_d_upd | output | 1 | Port D changed at last edge |
| busy_o | output | 18 | Per-channel pending flag |

## Verification
Two kinds of event can fall in the same cycle here. A host command can reach a channel at the very edge its transition falls due, and two channels of one port can fire at the same edge. The bench provokes the first by issuing a stop exactly N cycles after an arm. It judges this by confirming that the byte never changes and that busy is already low. It provokes the second by arming two port C channels one cycle apart, with durations that differ by one. It then expects both bits flipped in one byte under a single one-cycle strobe, with the strobe low again on the following cycle.

// File: rtl/ptg_pkg.sv
// Package: shared constants, command codes and the fixed channel-to-pin map.
// Assumes the map is fixed: port A {7,2,1,0}, port C {0..7}, port D {0..5}.
package ptg_pkg;
    localparam int NUM_CH = 18;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int PORT_W = 8;

    typedef enum logic [1:0] {
        PSEL_A = 2'd0,
        PSEL_C = 2'd1,
        PSEL_D = 2'd2
    } port_sel_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ARM  = 2'd1,
        OP_STOP = 2'd2
    } cmd_op_e;

    // Port driven by channel idx.
    function automatic port_sel_e chan_port(input int idx);
        if (idx < 4)       return PSEL_A;
        else if (idx < 12) return PSEL_C;
        else               return PSEL_D;
    endfunction

    // Bit position within its port driven by channel idx.
    function automatic logic [2:0] chan_bit(input int idx);
        logic [2:0] b;
        if (idx < 4) begin
            case (idx)
                0:       b = 3'd7;
                1:       b = 3'd2;
                2:       b = 3'd1;
                default: b = 3'd0;
            endcase
        end else if (idx < 12) begin
            b = 3'(idx - 4);
        end else begin
            b = 3'(idx - 12);
        end
        return b;
    endfunction
endpackage

// File: rtl/ptg_cmd_decode.sv
// Command decoder: turns one host command into one-hot arm/stop strobes.
// Assumes at most one command per cycle; indices at or above NCH are dropped.
module ptg_cmd_decode
    import ptg_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int CW  = CH_W
) (
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_op,
    input  logic [CW-1:0]  cmd_chan,
    output logic [NCH-1:0] arm_vec,
    output logic [NCH-1:0] stop_vec
);
    // Select the addressed channel for an in-range arm or stop.
    always_comb begin
        arm_vec  = '0;
        stop_vec = '0;
        if (cmd_valid && (32'(cmd_chan) < NCH)) begin
            if (cmd_op == OP_ARM)
                arm_vec[cmd_chan] = 1'b1;
            else if (cmd_op == OP_STOP)
                stop_vec[cmd_chan] = 1'b1;
        end
    end
endmodule

// File: rtl/ptg_channel.sv
// One toggle channel: interval down-counter, repeat counter, stored durations.
// Assumes pin_lvl is the channel's own bit as registered before this edge.
// Priority at an edge: cancel_all, then stop, then arm, then own expiry.
module ptg_channel #(
    parameter int CNT_W = 32,
    parameter int REP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cancel_all,
    input  logic             arm,
    input  logic             stop,
    input  logic [CNT_W-1:0] hi_len,
    input  logic [CNT_W-1:0] lo_len,
    input  logic [REP_W-1:0] rep_init,
    input  logic             pin_lvl,
    output logic             fire,
    output logic             busy
);
    localparam logic [CNT_W-1:0] ONE_CYC     = CNT_W'(1);
    localparam logic [REP_W-1:0] REP_FOREVER = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] hi_q;
    logic [CNT_W-1:0] lo_q;
    logic [REP_W-1:0] rep_q;
    logic             busy_q;
    logic [CNT_W-1:0] hi_eff;
    logic [CNT_W-1:0] lo_eff;

    // Clamp programmed durations to a minimum of one cycle.
    always_comb begin
        hi_eff = (hi_len == '0) ? ONE_CYC : hi_len;
        lo_eff = (lo_len == '0) ? ONE_CYC : lo_len;
    end

    // Expiry of the current interval, suppressed by any same-edge command.
    always_comb begin
        fire = busy_q && (cnt_q == ONE_CYC) && !arm && !stop && !cancel_all;
    end

    assign busy = busy_q;

    // Channel state: arm, cancel, count down, reload or retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hi_q   <= ONE_CYC;
            lo_q   <= ONE_CYC;
            rep_q  <= '0;
            busy_q <= 1'b0;
        end else if (cancel_all) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (stop) begin
            cnt_q  <= '0;
            rep_q  <= '0;
            busy_q <= 1'b0;
        end else if (arm) begin
            hi_q   <= hi_eff;
            lo_q   <= lo_eff;
            rep_q  <= rep_init;
            cnt_q  <= pin_lvl ? hi_eff : lo_eff;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q == ONE_CYC) begin
                if (rep_q == '0) begin
                    cnt_q  <= '0;
                    busy_q <= 1'b0;
                end else begin
                    if (rep_q != REP_FOREVER)
                        rep_q <= rep_q - 1'b1;
                    // Bit flips now: was 1 -> low next, was 0 -> high next.
                    cnt_q <= pin_lvl ? lo_q : hi_q;
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R13: a pending channel always holds a live, nonzero interval.
    a_r13_busy_counting: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q != '0));

    // R3: an uncontested arm leaves the channel pending.
    a_r3_arm_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !stop && !cancel_all) |=> busy_q);

    // R8: a stop idles the channel at the next edge.
    a_r8_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !busy_q);

    // R5: expiry with no repeats left retires the channel.
    a_r5_last_transition: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (rep_q == '0)) |=> !busy_q);
endmodule

// File: rtl/ptg_port.sv
// One port image register: applies the merged flip mask of its channels and
// raises a one-cycle update strobe on any change.
// Assumes flip only carries bits inside MOVABLE; others are masked anyway.
module ptg_port
    import ptg_pkg::*;
#(
    parameter logic [PORT_W-1:0] MOVABLE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] flip,
    output logic [PORT_W-1:0] port_q,
    output logic              upd
);
    logic [PORT_W-1:0] flip_ok;

    // Restrict flips to bits that have a channel.
    always_comb flip_ok = flip & MOVABLE;

    // Register the new byte and the change strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
            upd    <= 1'b0;
        end else begin
            port_q <= port_q ^ flip_ok;
            upd    <= |flip_ok;
        end
    end

    // R2: bits without a channel stay at their reset value.
    a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (port_q & ~MOVABLE) == '0);

    // R12: the byte changes exactly when the strobe is raised.
    a_r12_strobe_match: assert property (@(posedge clk) disable iff (!rst_n)
        upd == (port_q != $past(port_q)));
endmodule

// File: rtl/pin_toggle_gen.sv
// Top: eighteen toggle channels over three port images with a host command
// port. Assumes one command per cycle and a fixed channel-to-bit map.
module pin_toggle_gen
    import ptg_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int REP_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cancel_all,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [CH_W-1:0]   cmd_chan,
    input  logic [CNT_W-1:0]  cmd_hi,
    input  logic [CNT_W-1:0]  cmd_lo,
    input  logic [REP_W-1:0]  cmd_rep,
    output logic [PORT_W-1:0] port_a_o,
    output logic              port_a_upd,
    output logic [PORT_W-1:0] port_c_o,
    output logic              port_c_upd,
    output logic [PORT_W-1:0] port_d_o,
    output logic              port_d_upd,
    output logic [NUM_CH-1:0] busy_o
);
    localparam logic [PORT_W-1:0] MOVE_A = 8'h87;
    localparam logic [PORT_W-1:0] MOVE_C = 8'hFF;
    localparam logic [PORT_W-1:0] MOVE_D = 8'h3F;

    logic [NUM_CH-1:0] arm_vec;
    logic [NUM_CH-1:0] stop_vec;
    logic [NUM_CH-1:0] fire_vec;
    logic [PORT_W-1:0] flip_a;
    logic [PORT_W-1:0] flip_c;
    logic [PORT_W-1:0] flip_d;

    ptg_cmd_decode #(.NCH(NUM_CH), .CW(CH_W)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_chan  (cmd_chan),
        .arm_vec   (arm_vec),
        .stop_vec  (stop_vec)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam port_sel_e  PSEL = chan_port(g);
        localparam logic [2:0] PBIT = chan_bit(g);
        logic lvl;

        if (PSEL == PSEL_A) begin : g_a
            assign lvl = port_a_o[PBIT];
        end else if (PSEL == PSEL_C) begin : g_c
            assign lvl = port_c_o[PBIT];
        end else begin : g_d
            assign lvl = port_d_o[PBIT];
        end

        ptg_channel #(.CNT_W(CNT_W), .REP_W(REP_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .cancel_all (cancel_all),
            .arm        (arm_vec[g]),
            .stop       (stop_vec[g]),
            .hi_len     (cmd_hi),
            .lo_len     (cmd_lo),
            .rep_init   (cmd_rep),
            .pin_lvl    (lvl),
            .fire       (fire_vec[g]),
            .busy       (busy_o[g])
        );
    end

    // Merge channel expiries into one flip mask per port.
    always_comb begin
        flip_a = '0;
        flip_c = '0;
        flip_d = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (fire_vec[i]) begin
                case (chan_port(i))
                    PSEL_A:  flip_a[chan_bit(i)] = 1'b1;
                    PSEL_C:  flip_c[chan_bit(i)] = 1'b1;
                    default: flip_d[chan_bit(i)] = 1'b1;
                endcase
            end
        end
    end

    ptg_port #(.MOVABLE(MOVE_A)) u_port_a (
        .clk (clk), .rst_n (rst_n), .flip (flip_a), .port_q (port_a_o), .upd (port_a_upd)
    );
    ptg_port #(.MOVABLE(MOVE_C)) u_port_c (
        .clk (clk), .rst_n (rst_n), .flip (flip_c), .port_q (port_c_o), .upd (port_c_upd)
    );
    ptg_port #(.MOVABLE(MOVE_D)) u_port_d (
        .clk (clk), .rst_n (rst_n), .flip (flip_d), .port_q (port_d_o), .upd (port_d_upd)
    );

    // R11: an out-of-range command never makes an idle channel busy.
    a_r11_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (32'(cmd_chan) >= NUM_CH)) |=> ((busy_o & ~$past(busy_o)) == '0));

    // R9: a global cancel leaves nothing pending.
    a_r9_cancel_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_all |=> (busy_o == '0));
endmodule

// File: tb/pin_toggle_gen_bench.sv
// Bench: sweeps every channel under several duration/repeat patterns, plus
// stop, cancel, re-arm, merge, zero-duration and out-of-range cases.
module pin_toggle_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cancel_all = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [4:0]  cmd_chan = '0;
    logic [31:0] cmd_hi = '0;
    logic [31:0] cmd_lo = '0;
    logic [31:0] cmd_rep = '0;
    logic [7:0]  port_a_o, port_c_o, port_d_o;
    logic        port_a_upd, port_c_upd, port_d_upd;
    logic [17:0] busy_o;

    int checks = 0;
    int failures = 0;
    logic [7:0] ex [3];

    localparam logic [1:0] ARM  = 2'b01;
    localparam logic [1:0] STOP = 2'b10;

    pin_toggle_gen u_pin_toggle_gen (
        .clk (clk), .rst_n (rst_n), .cancel_all (cancel_all),
        .cmd_valid (cmd_valid), .cmd_op (cmd_op), .cmd_chan (cmd_chan),
        .cmd_hi (cmd_hi), .cmd_lo (cmd_lo), .cmd_rep (cmd_rep),
        .port_a_o (port_a_o), .port_a_upd (port_a_upd),
        .port_c_o (port_c_o), .port_c_upd (port_c_upd),
        .port_d_o (port_d_o), .port_d_upd (port_d_upd),
        .busy_o (busy_o)
    );

    always #4 clk = ~clk;

    function automatic int bport(input int ch);
        return (ch < 4) ? 0 : ((ch < 12) ? 1 : 2);
    endfunction

    function automatic int bbit(input int ch);
        if (ch < 4) return (ch == 0) ? 7 : (3 - ch);
        else if (ch < 12) return ch - 4;
        else return ch - 12;
    endfunction

    function automatic logic [23:0] act_all();
        return {port_a_o, port_c_o, port_d_o};
    endfunction

    function automatic logic [23:0] exp_all();
        return {ex[0], ex[1], ex[2]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint a, input longint e);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, a, e);
        end
    endtask

    // Drive one command at the current negedge; sampled at the next posedge.
    task automatic cmd(input logic [1:0] op, input int ch,
                       input longint hi, input longint lo, input longint rep);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_chan  = ch[4:0];
        cmd_hi    = hi[31:0];
        cmd_lo    = lo[31:0];
        cmd_rep   = rep[31:0];
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 2'b00;
    endtask

    task automatic hold_check(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(act_all() === exp_all(), req, "port bytes held", act_all(), exp_all());
        end
    endtask

    // Arm a channel and compare every cycle against the arithmetic schedule.
    task automatic run_seq(input int ch, input longint hi, input longint lo,
                           input longint rep, input int limit, input string tag);
        int p, b;
        logic cur;
        longint eh, el, left, next_t;
        logic [2:0] sexp;
        p  = bport(ch);
        b  = bbit(ch);
        eh = (hi == 0) ? 1 : hi;
        el = (lo == 0) ? 1 : lo;
        cur = ex[p][b];
        cmd(ARM, ch, hi, lo, rep);
        chk(busy_o[ch] === 1'b1, "R13", "busy after arm", busy_o[ch], 1);
        next_t = cur ? eh : el;
        left   = rep + 1;
        for (int j = 1; left > 0 && j <= limit; j++) begin
            @(negedge clk);
            sexp = '0;
            if (j == next_t) begin
                ex[p][b] = ~ex[p][b];
                cur = ex[p][b];
                left--;
                next_t = j + (cur ? eh : el);
                sexp[2 - p] = 1'b1;
            end
            chk(act_all() === exp_all(), tag, "port bytes", act_all(), exp_all());
            chk({port_a_upd, port_c_upd, port_d_upd} === sexp, "R12", "update strobes",
                {port_a_upd, port_c_upd, port_d_upd}, sexp);
            if (left == 0)
                chk(busy_o[ch] === 1'b0, "R5", "busy after last transition", busy_o[ch], 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        ex[0] = '0; ex[1] = '0; ex[2] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(act_all() === 24'h0, "R1", "ports in reset", act_all(), 0);
        chk({port_a_upd, port_c_upd, port_d_upd} === 3'b000, "R1", "strobes in reset",
            {port_a_upd, port_c_upd, port_d_upd}, 0);
        chk(busy_o === 18'h0, "R1", "busy in reset", busy_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep pass 1: every channel, mixed durations incl. zero (R2 R3 R4 R5 R11)
        for (int ch = 0; ch < 18; ch++)
            run_seq(ch, ch % 3, (ch + 1) % 3, ch % 4, 200, "R2 R3 R4 R11");
        // Sweep pass 2: start bits now differ, so high-first starts occur (R3)
        for (int ch = 0; ch < 18; ch++)
            run_seq(ch, (ch % 2) + 2, 1, (ch + 1) % 3, 200, "R3 R4 R2");

        // R7: zero durations toggle every cycle
        run_seq(15, 0, 0, 3, 20, "R7");

        // R6: unlimited repeat keeps running
        run_seq(13, 1, 2, 64'hFFFF_FFFF, 40, "R6");
        chk(busy_o[13] === 1'b1, "R6", "still busy", busy_o[13], 1);
        cmd(STOP, 13, 0, 0, 0);
        chk(busy_o[13] === 1'b0, "R8", "busy after stop", busy_o[13], 0);
        hold_check(6, "R8");

        // R8: stop mid-interval
        cmd(ARM, 7, 5, 5, 3);
        repeat (2) @(negedge clk);
        cmd(STOP, 7, 0, 0, 0);
        chk(busy_o[7] === 1'b0, "R8", "busy after stop", busy_o[7], 0);
        hold_check(8, "R8");

        // R8: stop lands on the edge the transition falls due
        cmd(ARM, 8, 3, 3, 2);
        repeat (2) @(negedge clk);
        cmd(STOP, 8, 0, 0, 0);
        chk(act_all() === exp_all(), "R8", "no toggle at stop edge", act_all(), exp_all());
        chk(busy_o[8] === 1'b0, "R8", "busy at stop edge", busy_o[8], 0);
        hold_check(6, "R8");

        // R10: re-arm discards the old schedule
        cmd(ARM, 9, 12, 12, 0);
        repeat (3) @(negedge clk);
        run_seq(9, 2, 2, 0, 50, "R10");
        hold_check(14, "R10");

        // R9: global cancel
        cmd(ARM, 0, 6, 6, 5);
        cmd(ARM, 4, 6, 6, 5);
        cmd(ARM, 14, 6, 6, 5);
        cancel_all = 1'b1;
        @(negedge clk);
        cancel_all = 1'b0;
        chk(busy_o === 18'h0, "R9", "busy after cancel", busy_o, 0);
        hold_check(10, "R9");

        // R11: out-of-range indices do nothing
        for (int ch = 18; ch < 32; ch++)
            cmd(ARM, ch, 1, 1, 0);
        chk(busy_o === 18'h0, "R11", "busy after bad index", busy_o, 0);
        hold_check(3, "R11");

        // R12: two port C channels fire at the same edge
        cmd(ARM, 10, 4, 4, 0);
        cmd(ARM, 11, 3, 3, 0);
        hold_check(2, "R12");
        @(negedge clk);
        ex[1][6] = ~ex[1][6];
        ex[1][7] = ~ex[1][7];
        chk(act_all() === exp_all(), "R12", "merged byte", act_all(), exp_all());
        chk({port_a_upd, port_c_upd, port_d_upd} === 3'b010, "R12", "single strobe",
            {port_a_upd, port_c_upd, port_d_upd}, 3'b010);
        @(negedge clk);
        chk({port_a_upd, port_c_upd, port_d_upd} === 3'b000, "R12", "strobe one cycle",
            {port_a_upd, port_c_upd, port_d_upd}, 0);
        chk(busy_o[11:10] === 2'b00, "R5", "both retired", busy_o[11:10], 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule